// File: doc/BRIEF.md
# Programmable At-Speed Scan Clock Controller

This block sits between the scan test clock, the fast functional clock and the scan flops. In test mode it emits the slow shift clock while a pattern is loaded. Near the end of the load it switches to the fast clock for a short burst: a programmable number of fast shift pulses, then a launch pulse and a capture pulse. The fast shift pulses replace the last slow shift cycles, so the data loaded into the chains does not change. Switching activity ramps up over several fast cycles before the launch and capture, which limits sudden current steps and supply droop. With the extra count at zero, the block behaves like a plain two-pulse launch/capture controller.

A small register path stands in for a boundary-scan data register. It holds the extra pulse count and the scan chain length. Writes are refused while a pattern is in progress. A pattern begins on a rising edge of the scan enable input, seen on the slow clock while test mode is on. The controller drives the scan enable seen by the flops. It pulls that enable low for the capture pulse only, and reports busy and a one-cycle done flag. When test mode is off, the output clock is the fast clock passed straight through.

Top module: `at_speed_clk_ctrl`

## Requirements
- R1: After reset in test mode, with no pattern started, busy and done are 0, the output clock gives no pulses and the scan enable output equals the scan enable input.
- R2: While test mode is low, the output clock follows the fast clock at all times.
- R3: With an extra count of 0, a pattern gives exactly L slow pulses followed by exactly 2 fast pulses, where L is the chain length.
- R4: With an extra count N not above L, a pattern gives L−N slow pulses followed by N+2 fast pulses. The total number of shift pulses stays L, and no slow pulse follows a fast one.
- R5: An extra count above L is limited to L: the pattern gives 0 slow pulses and L+2 fast pulses.
- R6: The scan enable output is high at the rise of every pulse of a pattern except the last fast (capture) pulse. After that pulse it is high again.
- R7: The slow and fast gate enables are never both active. Every output pulse has a full slow or full fast high time, with no runt pulse.
- R8: Done is high for exactly one slow cycle per pattern, after the capture pulse, and only while busy.
- R9: Busy rises within two slow cycles of the start. While busy is high, configuration writes are ignored, and the next pattern uses the earlier values.
- R10: A pattern starts only on a rising edge of scan enable in, while idle and in test mode. Keeping scan enable high after done starts no second burst.
- R11: A write with select 0 loads the extra count from the low 4 bits of the write data. A write with select 1 loads the 16-bit chain length. The reset values are count 0 and length 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow scan shift clock; also clocks the sequencer and registers |
| clk_fast | input | 1 | Fast functional clock from the PLL |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | High selects gated test clocking; low passes the fast clock through |
| scan_en_in | input | 1 | Scan enable from the tester; its rising edge starts a pattern |
| cfg_wr_en | input | 1 | Configuration write strobe (slow clock) |
| cfg_sel | input | 1 | 0 selects the extra count, 1 selects the chain length |
| cfg_wdata | input | 16 | Configuration write data |
| clk_out | output | 1 | Gated clock to the scan flops |
| scan_en_out | output | 1 | Scan enable to the flops; low for the capture pulse |
| busy | output | 1 | A pattern is in progress |
| done | output | 1 | One slow-cycle pulse after a pattern completes |

## Verification
Busy is registered on the slow edge that sees the rising scan enable. The bench checks it two slow falling edges after the start. The first slow pulse comes one slow cycle after the start. The fast burst then waits for a two-flop handshake into the fast domain. Done follows the last capture pulse by a two-flop return handshake of two to three slow cycles. The bench therefore does not predict exact cycles for the burst. It waits for done, lets three more slow cycles pass, and then compares the pulse counts. Pulses are sorted by their measured high time, and the scan enable is sampled at each pulse rise, when it cannot be changing. Done is sampled on slow falling edges, half a cycle after the edge that moves it.

// File: rtl/occ_pkg.sv
`timescale 1ns/1ps
// Package: shared types and encodings for the at-speed clock controller.
// Assumes: nothing; types only.
package occ_pkg;

    // Slow-domain sequencer phases of one pattern.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SHIFT  = 2'd1,
        SEQ_BURST  = 2'd2,
        SEQ_FINISH = 2'd3
    } seq_state_t;

    // Fast-domain burst phases.
    typedef enum logic [1:0] {
        FB_IDLE  = 2'd0,
        FB_RUN   = 2'd1,
        FB_HOLD  = 2'd2
    } burst_state_t;

    // Configuration select encoding.
    localparam logic CFG_SEL_EXTRA = 1'b0;
    localparam logic CFG_SEL_LEN   = 1'b1;

endpackage

// File: rtl/occ_sync2.sv
`timescale 1ns/1ps
// Module: multi-flop level synchronizer.
// Moves a level signal into the domain of clk. Assumes the input is a
// level held for several destination cycles (a request or acknowledge).
module occ_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    // Purpose: shift the level through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/occ_cfg_regs.sv
`timescale 1ns/1ps
// Module: configuration registers for the clock controller.
// Holds the extra fast-pulse count and the scan chain length. Derives the
// number of slow shifts and the size of the fast burst; the count is
// limited to the chain length. Assumes LEN_W > CNT_W and writes are
// synchronous to the slow clock.
module occ_cfg_regs
    import occ_pkg::*;
#(
    parameter int                CNT_W   = 4,
    parameter int                LEN_W   = 16,
    parameter logic [LEN_W-1:0]  LEN_RST = 16'd8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [LEN_W-1:0] wdata,
    input  logic             busy,
    output logic [CNT_W-1:0] extra_q,
    output logic [LEN_W-1:0] len_q,
    output logic [LEN_W-1:0] slow_shifts,
    output logic [CNT_W:0]   fast_pulses
);
    localparam int PAD_W = LEN_W - CNT_W;

    logic [LEN_W-1:0] extra_ext;
    logic             clamp;
    logic [CNT_W-1:0] eff_cnt;

    // Purpose: accept writes only while no pattern is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            extra_q <= '0;
            len_q   <= LEN_RST;
        end else if (wr_en && !busy) begin
            if (sel == CFG_SEL_EXTRA) begin
                extra_q <= wdata[CNT_W-1:0];
            end else begin
                len_q <= wdata;
            end
        end
    end

    // Purpose: limit the count to the chain length and split the load.
    always_comb begin
        extra_ext   = {{PAD_W{1'b0}}, extra_q};
        clamp       = (extra_ext > len_q);
        eff_cnt     = clamp ? len_q[CNT_W-1:0] : extra_q;
        slow_shifts = clamp ? '0 : (len_q - extra_ext);
        fast_pulses = {1'b0, eff_cnt} + (CNT_W+1)'(2);
    end
endmodule

// File: rtl/occ_slow_seq.sv
`timescale 1ns/1ps
// Module: slow-domain pattern sequencer.
// Detects the start of a pattern, runs the slow shift pulses, hands the
// end of the load to the fast domain by a level request, and reports
// busy and done. The slow gate enable changes only on the falling edge
// of the slow clock, so the gated slow pulses are always whole.
// Assumes burst_ack is already synchronized to clk_slow.
module occ_slow_seq
    import occ_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             scan_en_in,
    input  logic [LEN_W-1:0] slow_shifts,
    input  logic             burst_ack,
    output logic             slow_gate_en,
    output logic             burst_req,
    output logic             busy,
    output logic             done
);
    seq_state_t       state_q;
    logic [LEN_W-1:0] rem_q;
    logic             se_prev_q;
    logic             start;

    // Purpose: a pattern starts on a rising scan enable while idle in test mode.
    assign start = test_mode && scan_en_in && !se_prev_q && (state_q == SEQ_IDLE);

    // Purpose: remember the previous scan enable for edge detection.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            se_prev_q <= 1'b0;
        end else begin
            se_prev_q <= scan_en_in;
        end
    end

    // Purpose: sequence shift, burst hand-off and completion.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            rem_q     <= '0;
            burst_req <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_SHIFT;
                        rem_q   <= slow_shifts;
                    end
                end
                SEQ_SHIFT: begin
                    if (slow_gate_en) begin
                        rem_q <= rem_q - LEN_W'(1);
                    end else if (rem_q == '0) begin
                        state_q   <= SEQ_BURST;
                        burst_req <= 1'b1;
                    end
                end
                SEQ_BURST: begin
                    if (burst_ack) begin
                        burst_req <= 1'b0;
                        done      <= 1'b1;
                        state_q   <= SEQ_FINISH;
                    end
                end
                SEQ_FINISH: begin
                    if (!burst_ack) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Purpose: open the slow gate on the falling edge only while shifts remain.
    always_ff @(negedge clk_slow) begin
        if (!rst_n) begin
            slow_gate_en <= 1'b0;
        end else begin
            slow_gate_en <= (state_q == SEQ_SHIFT) && (rem_q != '0);
        end
    end

    assign busy = (state_q != SEQ_IDLE);
endmodule

// File: rtl/occ_fast_burst.sv
`timescale 1ns/1ps
// Module: fast-domain burst generator.
// Synchronizes the burst request, then opens the fast gate for exactly
// fast_pulses rising edges. It marks the final pulse as the capture pulse
// and returns a level acknowledge that is held until the request drops.
// All gate and phase flops change on the falling fast edge, so the pulses
// are whole. Assumes fast_pulses is stable while the request is high.
module occ_fast_burst
    import occ_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk_fast,
    input  logic           rst_n,
    input  logic           burst_req,
    input  logic [CNT_W:0] fast_pulses,
    output logic           fast_gate_en,
    output logic           capture_phase,
    output logic           burst_ack
);
    burst_state_t   state_q;
    logic [CNT_W:0] left_q;
    logic           req_s;

    // Purpose: bring the slow-domain request into the fast domain.
    occ_sync2 #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .d     (burst_req),
        .q     (req_s)
    );

    // Purpose: count the burst pulses and mark the capture pulse.
    always_ff @(negedge clk_fast) begin
        if (!rst_n) begin
            state_q       <= FB_IDLE;
            left_q        <= '0;
            fast_gate_en  <= 1'b0;
            capture_phase <= 1'b0;
            burst_ack     <= 1'b0;
        end else begin
            case (state_q)
                FB_IDLE: begin
                    if (req_s) begin
                        fast_gate_en  <= 1'b1;
                        left_q        <= fast_pulses - (CNT_W+1)'(1);
                        capture_phase <= 1'b0;
                        state_q       <= FB_RUN;
                    end
                end
                FB_RUN: begin
                    if (left_q == '0) begin
                        fast_gate_en  <= 1'b0;
                        capture_phase <= 1'b0;
                        burst_ack     <= 1'b1;
                        state_q       <= FB_HOLD;
                    end else begin
                        left_q        <= left_q - (CNT_W+1)'(1);
                        capture_phase <= (left_q == (CNT_W+1)'(1));
                    end
                end
                FB_HOLD: begin
                    if (!req_s) begin
                        burst_ack <= 1'b0;
                        state_q   <= FB_IDLE;
                    end
                end
                default: state_q <= FB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/at_speed_clk_ctrl.sv
`timescale 1ns/1ps
// Module: programmable at-speed scan clock controller (top).
// In test mode the output clock is the gated slow clock during the load,
// then a burst of fast pulses (extra shifts, launch, capture). Out of test
// mode the fast clock passes straight through. The scan enable output
// drops only for the capture pulse. Assumes test_mode is static while a
// pattern runs, and rst_n is held for several cycles of both clocks.
module at_speed_clk_ctrl
    import occ_pkg::*;
#(
    parameter int                CNT_W       = 4,
    parameter int                LEN_W       = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [LEN_W-1:0]  LEN_RST     = 16'd8
) (
    input  logic             clk_slow,
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             scan_en_in,
    input  logic             cfg_wr_en,
    input  logic             cfg_sel,
    input  logic [LEN_W-1:0] cfg_wdata,
    output logic             clk_out,
    output logic             scan_en_out,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] extra_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] slow_shifts;
    logic [CNT_W:0]   fast_pulses;
    logic             slow_gate_en;
    logic             fast_gate_en;
    logic             capture_phase;
    logic             burst_req;
    logic             burst_ack_f;
    logic             burst_ack_s;

    occ_cfg_regs #(.CNT_W(CNT_W), .LEN_W(LEN_W), .LEN_RST(LEN_RST)) i_cfg (
        .clk         (clk_slow),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .sel         (cfg_sel),
        .wdata       (cfg_wdata),
        .busy        (busy),
        .extra_q     (extra_q),
        .len_q       (len_q),
        .slow_shifts (slow_shifts),
        .fast_pulses (fast_pulses)
    );

    occ_slow_seq #(.LEN_W(LEN_W)) i_seq (
        .clk_slow     (clk_slow),
        .rst_n        (rst_n),
        .test_mode    (test_mode),
        .scan_en_in   (scan_en_in),
        .slow_shifts  (slow_shifts),
        .burst_ack    (burst_ack_s),
        .slow_gate_en (slow_gate_en),
        .burst_req    (burst_req),
        .busy         (busy),
        .done         (done)
    );

    // Purpose: return the fast-domain acknowledge to the slow domain.
    occ_sync2 #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .d     (burst_ack_f),
        .q     (burst_ack_s)
    );

    occ_fast_burst #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_burst (
        .clk_fast      (clk_fast),
        .rst_n         (rst_n),
        .burst_req     (burst_req),
        .fast_pulses   (fast_pulses),
        .fast_gate_en  (fast_gate_en),
        .capture_phase (capture_phase),
        .burst_ack     (burst_ack_f)
    );

    // Purpose: combine the two gated clocks, or bypass outside test mode.
    assign clk_out = test_mode ? ((clk_slow & slow_gate_en) | (clk_fast & fast_gate_en))
                               : clk_fast;

    // Purpose: drop the scan enable for the capture pulse only.
    assign scan_en_out = scan_en_in & ~capture_phase;
endmodule

// File: rtl/occ_checker.sv
`timescale 1ns/1ps
// Module: property checker for the at-speed clock controller, bound to the top.
module occ_checker #(
    parameter int CNT_W = 4,
    parameter int LEN_W = 16
) (
    input logic             clk_slow,
    input logic             clk_fast,
    input logic             rst_n,
    input logic             slow_gate_en,
    input logic             fast_gate_en,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] extra_q,
    input logic [LEN_W-1:0] len_q
);
    // R7: the two gate enables never overlap.
    assert_gate_excl_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !(slow_gate_en && fast_gate_en));

    // R8: done lasts a single slow cycle.
    assert_done_single_R8: assert property (@(posedge clk_slow) disable iff (!rst_n)
        done |=> !done);

    // R8: done appears only while a pattern is still marked busy.
    assert_done_busy_R8: assert property (@(posedge clk_slow) disable iff (!rst_n)
        done |-> busy);

    // R9: configuration holds while busy.
    assert_cfg_hold_R9: assert property (@(posedge clk_slow) disable iff (!rst_n)
        busy |=> ($stable(extra_q) && $stable(len_q)));

    // R1: no fast gating outside a pattern.
    assert_idle_quiet_R1: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !busy |-> !fast_gate_en);
endmodule

bind at_speed_clk_ctrl occ_checker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_occ_checker (
    .clk_slow     (clk_slow),
    .clk_fast     (clk_fast),
    .rst_n        (rst_n),
    .slow_gate_en (slow_gate_en),
    .fast_gate_en (fast_gate_en),
    .busy         (busy),
    .done         (done),
    .extra_q      (extra_q),
    .len_q        (len_q)
);

// File: tb/test_at_speed_clk_ctrl.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random configurations, pulses
// classified by high time and compared with counts from bench functions.
module test_at_speed_clk_ctrl;
    localparam int SLOW_PERIOD = 50;
    localparam int FAST_PERIOD = 6;
    localparam int WATCHDOG    = SLOW_PERIOD * 20000;

    logic        clk_slow = 1'b0;
    logic        clk_fast = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_mode = 1'b1;
    logic        scan_en_in = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        clk_out;
    logic        scan_en_out;
    logic        busy;
    logic        done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Pulse monitor state.
    bit      mon_on = 0;
    realtime t_rise = 0.0;
    bit      se_rise = 1'b1;
    int      n_slow, n_fast, n_glitch, n_order, n_se_low, n_after_low, n_done;

    at_speed_clk_ctrl i_at_speed_clk_ctrl (
        .clk_slow    (clk_slow),
        .clk_fast    (clk_fast),
        .rst_n       (rst_n),
        .test_mode   (test_mode),
        .scan_en_in  (scan_en_in),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .clk_out     (clk_out),
        .scan_en_out (scan_en_out),
        .busy        (busy),
        .done        (done)
    );

    initial forever #(SLOW_PERIOD/2) clk_slow = ~clk_slow;
    initial forever #(FAST_PERIOD/2) clk_fast = ~clk_fast;

    // Record the rise time and the scan enable seen by the flops.
    always @(posedge clk_out) begin
        t_rise  = $realtime;
        se_rise = scan_en_out;
    end

    // Classify each finished pulse by its high time.
    always @(negedge clk_out) begin
        if (mon_on) begin
            realtime w;
            w = $realtime - t_rise;
            if (w > 20.0 && w < 30.0) begin
                n_slow++;
                if (n_fast > 0) n_order++;
            end else if (w > 2.0 && w < 4.0) begin
                n_fast++;
            end else begin
                n_glitch++;
            end
            if (n_se_low > 0) n_after_low++;
            if (!se_rise) n_se_low++;
        end
    end

    always @(negedge clk_slow) begin
        if (mon_on && done) n_done++;
    end

    function automatic int exp_slow(int len, int cnt);
        return (cnt > len) ? 0 : len - cnt;
    endfunction

    function automatic int exp_fast(int len, int cnt);
        return ((cnt > len) ? len : cnt) + 2;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_mon();
        n_slow = 0; n_fast = 0; n_glitch = 0; n_order = 0;
        n_se_low = 0; n_after_low = 0; n_done = 0;
    endtask

    task automatic write_cfg(bit sel, logic [15:0] data);
        @(negedge clk_slow); #1;
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk_slow); #1;
        cfg_wr_en = 1'b0;
    endtask

    // One pattern; the optional write during busy must have no effect.
    task automatic run_pattern(int len, int cnt, string req, bit mid_write);
        int tot;
        clear_mon();
        mon_on = 1;
        @(negedge clk_slow); #1;
        scan_en_in = 1'b1;
        @(negedge clk_slow); @(negedge clk_slow);
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        if (mid_write) begin
            write_cfg(1'b0, 16'd9);
            write_cfg(1'b1, 16'd3);
        end
        while (n_done == 0) @(negedge clk_slow);
        repeat (3) @(negedge clk_slow);
        check(n_slow == exp_slow(len, cnt), {req, " slow pulses"}, n_slow, exp_slow(len, cnt));
        check(n_fast == exp_fast(len, cnt), {req, " fast pulses"}, n_fast, exp_fast(len, cnt));
        check(n_order == 0, "R4 no slow after fast", n_order, 0);
        check(n_glitch == 0, "R7 runt pulses", n_glitch, 0);
        check(n_se_low == 1 && n_after_low == 0, "R6 capture-only low enable", n_se_low, 1);
        check(scan_en_out == 1'b1, "R6 enable back high", scan_en_out, 1);
        check(n_done == 1, "R8 done width", n_done, 1);
        tot = n_slow + n_fast;
        repeat (10) @(negedge clk_slow);
        check(n_slow + n_fast == tot, "R10 no restart with enable held", n_slow + n_fast, tot);
        check(busy == 1'b0, "R10 idle after pattern", busy, 0);
        scan_en_in = 1'b0;
        repeat (2) @(negedge clk_slow);
        mon_on = 0;
    endtask

    initial begin
        #(WATCHDOG);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (6) @(negedge clk_slow);
        rst_n = 1'b1;

        // R1: idle after reset in test mode.
        clear_mon();
        mon_on = 1;
        repeat (6) @(negedge clk_slow);
        check(n_slow + n_fast + n_glitch == 0, "R1 idle pulses", n_slow + n_fast + n_glitch, 0);
        check(busy == 1'b0 && done == 1'b0, "R1 status at reset", {busy, done}, 0);
        check(scan_en_out == scan_en_in, "R1 scan enable follows", scan_en_out, scan_en_in);
        mon_on = 0;

        // R2: bypass when test mode is low; R10: no start in bypass.
        @(negedge clk_slow); #1;
        test_mode = 1'b0;
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk_fast); #1;
                if (clk_out !== 1'b1) bad++;
                @(negedge clk_fast); #1;
                if (clk_out !== 1'b0) bad++;
            end
            check(bad == 0, "R2 fast pass-through", bad, 0);
        end
        scan_en_in = 1'b1;
        repeat (3) @(negedge clk_slow);
        check(busy == 1'b0, "R10 no start out of test mode", busy, 0);
        scan_en_in = 1'b0;
        @(negedge clk_slow); #1;
        test_mode = 1'b1;
        repeat (2) @(negedge clk_slow);

        // R3/R11: reset values (length 8, count 0).
        run_pattern(8, 0, "R3 R11 reset config", 1'b0);
        // R11: upper data bits ignored for the count.
        write_cfg(1'b1, 16'd12);
        write_cfg(1'b0, 16'hFFF5);
        run_pattern(12, 5, "R4 R11 count 5", 1'b0);
        // R9: writes during busy ignored; next pattern keeps 12/5.
        run_pattern(12, 5, "R9 busy write", 1'b1);
        run_pattern(12, 5, "R9 config kept", 1'b0);
        // R5: clamp and equal cases.
        write_cfg(1'b1, 16'd6);
        write_cfg(1'b0, 16'd15);
        run_pattern(6, 15, "R5 clamp", 1'b0);
        write_cfg(1'b1, 16'd7);
        write_cfg(1'b0, 16'd7);
        run_pattern(7, 7, "R4 count equals length", 1'b0);
        write_cfg(1'b1, 16'd0);
        write_cfg(1'b0, 16'd0);
        run_pattern(0, 0, "R5 zero length", 1'b0);

        // Random configurations (R3/R4/R5).
        for (int k = 0; k < 12; k++) begin
            int len = $urandom_range(0, 40);
            int cnt = $urandom_range(0, 15);
            write_cfg(1'b1, 16'(len));
            write_cfg(1'b0, 16'(cnt));
            run_pattern(len, cnt, "R4 random", 1'b0);
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule